// File: doc/BRIEF.md
# I2C Slave Address Matcher Receiver

This block is the front end of an I2C target on the bus. It watches the already synchronized clock and data lines, recognizes the Start and Stop conditions, and collects the first byte after each Start. The upper seven bits of that byte are compared with a programmable own address. On a match the block acknowledges and then acts as a receiver or as a transmitter, as the read/write bit selects. When enabled, the all-zero general call address is accepted as a second match, which always leads into reception.

Received data bytes go into a small holding buffer that the surrounding logic drains. Each accepted byte is acknowledged and marked by a one-cycle strobe. When the buffer has no free entry, the incoming byte is dropped and refused with a negative acknowledge. In transmit mode the block shifts out a byte supplied by the surrounding logic, most significant bit first. It stops driving once the controller refuses a byte.

The only bus output is a pull-down enable for the data line. Clock stretching and 10-bit addressing are not provided.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: After reset the pull-down is off, no byte is available and all flags are low. A Stop (data rising while clock high) returns the block to idle, releases the line and clears the match and read flags.
- R2: When the seven bits after a Start equal `own_addr_i`, the block pulls data low through the ninth clock. It sets `addr_match_o` and copies the eighth bit into `read_mode_o` (1 = read, the block transmits; 0 = write, the block receives).
- R3: When the address neither matches nor is a valid general call, the data line stays released for the rest of the transfer, and no data byte is stored or strobed.
- R4: The address byte 00h (seven zero address bits and a write bit) is acknowledged only while `gc_en_i` is 1, after which the following bytes are received. With `gc_en_i` at 0 it is not acknowledged.
- R5: In receive mode each data byte is pushed into the holding buffer and acknowledged on the ninth clock. `rx_strobe_o` is high for exactly one cycle per accepted byte. `rx_data_o` presents the oldest stored byte while `rx_avail_o` is 1, and `rx_pop_i` removes it.
- R6: When the holding buffer is full, an incoming data byte is refused: the line stays released on the ninth clock, no strobe is given and the stored bytes are unchanged.
- R7: In transmit mode the block drives `tx_byte_i`, most significant bit first, as a pull-down for each 0 bit. The byte is captured at the clock fall that ends the preceding acknowledge clock.
- R8: When the controller leaves data high on the ninth clock of a transmitted byte, the block drives nothing more until the next Start.
- R9: A Start (data falling while clock high) received in the middle of a byte restarts address reception with the bit count at zero, and the partial byte is discarded.
- R10: The pull-down enable changes only while the clock line is low.
- R11: `gc_flag_o` is set when a general call is acknowledged, survives Stop, and is cleared by `gc_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| own_addr_i | input | 7 | Own seven-bit address |
| gc_en_i | input | 1 | Accept the general call address |
| tx_byte_i | input | 8 | Byte to transmit in read transfers |
| rx_pop_i | input | 1 | Remove the oldest stored byte |
| gc_clr_i | input | 1 | Clear the sticky general-call flag |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| rx_data_o | output | 8 | Oldest stored received byte |
| rx_avail_o | output | 1 | Holding buffer not empty |
| rx_strobe_o | output | 1 | One-cycle mark of an accepted data byte |
| addr_match_o | output | 1 | Own address matched in this transfer |
| read_mode_o | output | 1 | Matched transfer is a read |
| gc_flag_o | output | 1 | Sticky general-call flag |

## Verification
The bus conditions and clock edges are found one clock after the input levels change. The pull-down, the strobe, the push and the flags are all registered at that same edge, so each result shows one clock after the bus event that causes it. The bench holds every bus level for four clocks and samples on the falling clock edge. It reads the acknowledge in the middle of the high phase of the ninth clock, and it reads the stored byte and the strobe count only after the whole byte has been clocked. Each check therefore lands several cycles after the result settles. A separate monitor in the bench compares the pull-down between successive samples taken while the clock is high.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and types of the I2C target front end.
// Assumes seven-bit addressing and eight-bit data bytes, both fixed by the bus.
package i2c_tgt_pkg;
    localparam int unsigned ADDR_BITS = 7;
    localparam int unsigned BYTE_BITS = 8;

    // What the engine is currently doing within a transfer.
    typedef enum logic [1:0] {
        ROLE_IDLE = 2'd0,
        ROLE_ADDR = 2'd1,
        ROLE_RX   = 2'd2,
        ROLE_TX   = 2'd3
    } role_e;
endpackage

// File: rtl/i2c_tgt_bus_cond.sv
// Bus event detector: clock edges and Start/Stop conditions.
// Assumes the inputs are already synchronized to clk. All outputs are
// single-cycle pulses that occur in the cycle the new level is first seen.
module i2c_tgt_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels; an idle bus is high on both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from the old and new levels.
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_tgt_fifo.sv
// Holding buffer for received bytes: a small first-in first-out store.
// Assumes the writer pushes only while full_o is low; pops on empty are ignored.
module i2c_tgt_fifo #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             avail_o,
    output logic             full_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Qualify the requests against the current fill level.
    always_comb begin
        full_o  = (count == FULL);
        avail_o = (count != '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && avail_o;
        head_o  = mem[rd_ptr];
    end

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    // Advance pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: the engine never pushes into a full store.
    p_push_has_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
endmodule

// File: rtl/i2c_tgt_engine.sv
// Bit and byte engine of the I2C target: address compare, acknowledge,
// reception into the holding buffer and transmission of a supplied byte.
// Assumes bus events from i2c_tgt_bus_cond. Data is sampled at clock rise;
// the pull-down is updated only at clock fall, while the clock is low.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 scl_rise_i,
    input  logic                 scl_fall_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic [ADDR_BITS-1:0] own_addr_i,
    input  logic                 gc_en_i,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    input  logic                 fifo_full_i,
    input  logic                 gc_clr_i,
    output logic                 sda_pull_o,
    output logic                 push_o,
    output logic [BYTE_BITS-1:0] push_data_o,
    output logic                 addr_match_o,
    output logic                 read_mode_o,
    output logic                 gc_flag_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);

    role_e                role;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-2:0] rx_sr;
    logic [BYTE_BITS-2:0] tx_sr;
    logic                 ack_go;
    logic [BYTE_BITS-1:0] rx_byte;
    logic                 addr_hit;
    logic                 gc_hit;

    // Form the byte as it will stand after this rise and decode the address.
    always_comb begin
        rx_byte  = {rx_sr, sda_i};
        addr_hit = (rx_byte[BYTE_BITS-1:1] == own_addr_i);
        gc_hit   = gc_en_i && (rx_byte == '0);
    end

    // Sequence bits, bytes and acknowledges through one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role         <= ROLE_IDLE;
            bit_cnt      <= '0;
            rx_sr        <= '0;
            tx_sr        <= '0;
            ack_go       <= 1'b0;
            sda_pull_o   <= 1'b0;
            push_o       <= 1'b0;
            push_data_o  <= '0;
            addr_match_o <= 1'b0;
            read_mode_o  <= 1'b0;
            gc_flag_o    <= 1'b0;
        end else begin
            push_o <= 1'b0;
            if (gc_clr_i) gc_flag_o <= 1'b0;
            if (start_i || stop_i) begin
                role         <= start_i ? ROLE_ADDR : ROLE_IDLE;
                bit_cnt      <= '0;
                ack_go       <= 1'b0;
                sda_pull_o   <= 1'b0;
                addr_match_o <= 1'b0;
                read_mode_o  <= 1'b0;
            end else if (scl_rise_i) begin
                if (bit_cnt == ACK_SLOT) begin
                    bit_cnt <= '0;
                    if (role == ROLE_TX && sda_i) role <= ROLE_IDLE;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sr   <= rx_byte[BYTE_BITS-2:0];
                    if (bit_cnt == LAST_DATA) begin
                        ack_go <= 1'b0;
                        case (role)
                            ROLE_ADDR: begin
                                if (addr_hit) begin
                                    ack_go       <= 1'b1;
                                    addr_match_o <= 1'b1;
                                    read_mode_o  <= rx_byte[0];
                                    role         <= rx_byte[0] ? ROLE_TX : ROLE_RX;
                                end else if (gc_hit) begin
                                    ack_go    <= 1'b1;
                                    gc_flag_o <= 1'b1;
                                    role      <= ROLE_RX;
                                end else begin
                                    role <= ROLE_IDLE;
                                end
                            end
                            ROLE_RX: begin
                                if (!fifo_full_i) begin
                                    ack_go      <= 1'b1;
                                    push_o      <= 1'b1;
                                    push_data_o <= rx_byte;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end else if (scl_fall_i) begin
                if (bit_cnt == ACK_SLOT) begin
                    sda_pull_o <= ack_go;
                end else if (bit_cnt == '0) begin
                    if (role == ROLE_TX) begin
                        tx_sr      <= tx_byte_i[BYTE_BITS-2:0];
                        sda_pull_o <= !tx_byte_i[BYTE_BITS-1];
                    end else begin
                        sda_pull_o <= 1'b0;
                    end
                end else if (role == ROLE_TX) begin
                    sda_pull_o <= !tx_sr[BYTE_BITS-2];
                    tx_sr      <= {tx_sr[BYTE_BITS-3:0], 1'b0};
                end
            end
        end
    end

    // R10: the pull-down moves only in a cycle whose clock level was low.
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) && !$past(start_i || stop_i) |-> !$past(scl_i));

    // R8: an idle engine never drives the line.
    p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_IDLE) |-> !sda_pull_o);

    // R5: the byte strobe is a single-cycle pulse.
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    // R1: Stop clears the address match.
    p_stop_clears_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !addr_match_o);

    // R9: any Start restarts address reception from bit zero.
    p_restart_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (role == ROLE_ADDR) && (bit_cnt == '0));

    // R11: the general-call flag holds until cleared.
    p_gc_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gc_flag_o && !gc_clr_i |=> gc_flag_o);
endmodule

// File: rtl/i2c_tgt_frontend.sv
// Top of the I2C target front end: bus event detector, bit/byte engine and
// receive holding buffer. Assumes synchronized line inputs and an external
// open-drain driver controlled by sda_pull_o.
module i2c_tgt_frontend
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [ADDR_BITS-1:0] own_addr_i,
    input  logic                 gc_en_i,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    input  logic                 rx_pop_i,
    input  logic                 gc_clr_i,
    output logic                 sda_pull_o,
    output logic [BYTE_BITS-1:0] rx_data_o,
    output logic                 rx_avail_o,
    output logic                 rx_strobe_o,
    output logic                 addr_match_o,
    output logic                 read_mode_o,
    output logic                 gc_flag_o
);
    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_ev;
    logic                 stop_ev;
    logic                 fifo_full;
    logic                 push;
    logic [BYTE_BITS-1:0] push_data;

    i2c_tgt_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_tgt_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_ev),
        .stop_i       (stop_ev),
        .own_addr_i   (own_addr_i),
        .gc_en_i      (gc_en_i),
        .tx_byte_i    (tx_byte_i),
        .fifo_full_i  (fifo_full),
        .gc_clr_i     (gc_clr_i),
        .sda_pull_o   (sda_pull_o),
        .push_o       (push),
        .push_data_o  (push_data),
        .addr_match_o (addr_match_o),
        .read_mode_o  (read_mode_o),
        .gc_flag_o    (gc_flag_o)
    );

    i2c_tgt_fifo #(
        .DEPTH (RX_DEPTH),
        .WIDTH (BYTE_BITS)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (push_data),
        .pop_i   (rx_pop_i),
        .head_o  (rx_data_o),
        .avail_o (rx_avail_o),
        .full_o  (fifo_full)
    );

    // The strobe is the accepted push itself.
    always_comb rx_strobe_o = push;
endmodule

// File: tb/sim_i2c_tgt_frontend.sv
// Directed bench for the I2C target front end; the bench acts as bus controller.
module sim_i2c_tgt_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic [7:0] tx_byte = 8'h00;
    logic       gc_en = 1'b0;
    logic       rx_pop = 1'b0;
    logic       gc_clr = 1'b0;
    logic       pull;
    logic [7:0] rx_data;
    logic       rx_avail, rx_strobe, match, rd_mode, gc_flag;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~pull;

    i2c_tgt_frontend u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .own_addr_i(OWN), .gc_en_i(gc_en), .tx_byte_i(tx_byte),
        .rx_pop_i(rx_pop), .gc_clr_i(gc_clr), .sda_pull_o(pull),
        .rx_data_o(rx_data), .rx_avail_o(rx_avail), .rx_strobe_o(rx_strobe),
        .addr_match_o(match), .read_mode_o(rd_mode), .gc_flag_o(gc_flag)
    );

    // Count strobes and watch the pull-down while the clock stays high (R10).
    always @(negedge clk) begin
        if (rx_strobe) strobes++;
        if (rst_n && scl && prev_scl && (pull != prev_pull)) r10_viol++;
        prev_scl  <= scl;
        prev_pull <= pull;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        acked = !sda_line;
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input bit m_ack, input logic [7:0] next_tx, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
            got = {got[6:0], sda_line};
            wq(Q); scl = 1'b0; wq(Q);
        end
        tx_byte = next_tx;
        sda_m = !m_ack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic pop_one;
        rx_pop = 1'b1; wq(1); rx_pop = 1'b0; wq(1);
    endtask

    task automatic t_reset;
        check(!pull && !rx_avail && !match && !rd_mode && !gc_flag, "R1 reset state",
              {pull, rx_avail, match, rd_mode, gc_flag}, 0);
    endtask

    task automatic t_write_and_full;
        bit a;
        int s0;
        s0 = strobes;
        bus_start();
        write_byte({OWN, 1'b0}, a);
        check(a, "R2 own address ack", a, 1);
        check(match && !rd_mode, "R2 match write", {match, rd_mode}, 2'b10);
        write_byte(8'h3C, a);
        check(a && rx_avail && rx_data == 8'h3C, "R5 first byte", {a, rx_avail, rx_data}, {2'b11, 8'h3C});
        write_byte(8'hA5, a);
        check(a && (strobes - s0) == 2, "R5 second byte strobe", strobes - s0, 2);
        write_byte(8'h77, a);
        check(!a, "R6 nack when full", a, 0);
        check((strobes - s0) == 2 && rx_data == 8'h3C, "R6 byte dropped", {strobes - s0, rx_data}, {32'd2, 8'h3C});
        bus_stop();
        check(!match && !pull, "R1 stop clears match", {match, pull}, 0);
        pop_one();
        check(rx_avail && rx_data == 8'hA5, "R5 second stored", {rx_avail, rx_data}, {1'b1, 8'hA5});
        pop_one();
        check(!rx_avail, "R5 drained", rx_avail, 0);
    endtask

    task automatic t_mismatch;
        bit a;
        int s0;
        s0 = strobes;
        bus_start();
        write_byte(8'h22, a);
        check(!a && !match, "R3 foreign address ignored", {a, match}, 0);
        write_byte(8'h00, a);
        check(!a && strobes == s0 && !rx_avail, "R3 foreign data ignored", {a, strobes - s0}, 0);
        bus_stop();
    endtask

    task automatic t_gc;
        bit a;
        gc_en = 1'b0;
        bus_start();
        write_byte(8'h00, a);
        check(!a && !gc_flag, "R4 general call disabled", {a, gc_flag}, 0);
        bus_stop();
        gc_en = 1'b1;
        bus_start();
        write_byte(8'h00, a);
        check(a && gc_flag && !match, "R4 general call acked", {a, gc_flag, match}, 3'b110);
        write_byte(8'h06, a);
        check(a && rx_data == 8'h06, "R4 general call payload", {a, rx_data}, {1'b1, 8'h06});
        bus_stop();
        check(gc_flag, "R11 flag survives stop", gc_flag, 1);
        gc_clr = 1'b1; wq(1); gc_clr = 1'b0; wq(1);
        check(!gc_flag, "R11 flag cleared", gc_flag, 0);
        pop_one();
        gc_en = 1'b0;
    endtask

    task automatic t_read;
        bit a;
        logic [7:0] got;
        tx_byte = 8'hC3;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        check(a && match && rd_mode, "R2 read address", {a, match, rd_mode}, 3'b111);
        read_byte(1'b1, 8'h5E, got);
        check(got == 8'hC3, "R7 first tx byte", got, 8'hC3);
        read_byte(1'b0, 8'h00, got);
        check(got == 8'h5E, "R7 second tx byte", got, 8'h5E);
        read_byte(1'b0, 8'h00, got);
        check(got == 8'hFF && !pull, "R8 silent after nack", got, 8'hFF);
        bus_stop();
    endtask

    task automatic t_restart;
        bit a;
        int s0;
        s0 = strobes;
        bus_start();
        write_byte({OWN, 1'b0}, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        check(strobes == s0 && !match, "R9 partial byte dropped", {strobes - s0, match}, 0);
        write_byte({OWN, 1'b0}, a);
        check(a && match, "R9 address after restart", {a, match}, 2'b11);
        write_byte(8'h99, a);
        check(a && rx_data == 8'h99 && (strobes - s0) == 1, "R9 byte after restart", rx_data, 8'h99);
        bus_stop();
        pop_one();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wq(4);
        rst_n = 1'b1;
        wq(2);
        t_reset();
        t_write_and_full();
        t_mismatch();
        t_gc();
        t_read();
        t_restart();
        check(r10_viol == 0, "R10 pull steady while clock high", r10_viol, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule